// File: doc/BRIEF.md
# Data Address Generator with Pointer Write-Back and Region Decode

This block produces the effective data-memory address for one load or store per cycle. It supports five addressing modes. Direct mode takes a full address from the instruction. The four indirect forms start from one of three 16-bit pointer pairs, X, Y or Z, which live in the top six general registers. They are plain, base plus a 6-bit unsigned displacement, decrement-then-use, and use-then-increment. For the two auto-modifying modes, the block also returns the updated pointer value and a write enable, so that the register file can store the pointer back.

The block also maps the effective address onto one linear data space. The first 32 locations are the working registers and the next 64 are I/O. The 1024 locations after those are internal SRAM, so the last decoded address is 1119. The block outputs a one-hot region select and the offset of the address within its region. Any address above the decoded space raises an out-of-range flag and selects no region. All outputs are registered, one cycle after the request.

Top module: `dag_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid`, `wb_en`, `out_of_range`, `region` and `eff_addr` are all zero.
- R2: Mode code 0 (direct) gives `eff_addr` equal to `direct_addr`, at any value in 0..65535, with `wb_en` low.
- R3: Mode code 1 (indirect) gives `eff_addr` equal to the selected pointer, with `wb_en` low. The select code is 0 for X, 1 for Y, 2 for Z, and 3 also selects Z. Mode codes 5 to 7 behave exactly like code 1.
- R4: Mode code 2 (displacement) gives `eff_addr` = pointer + zero-extended `disp` (0..63), modulo 2^16, with `wb_en` low.
- R5: Mode code 3 (pre-decrement) gives `eff_addr` = pointer − 1 modulo 2^16. It sets `wb_en`, sets `wb_val` to the same decremented value, and sets `wb_sel` to the pair used (0 X, 1 Y, 2 Z).
- R6: Mode code 4 (post-increment) gives `eff_addr` equal to the unmodified pointer. It sets `wb_en`, sets `wb_val` to pointer + 1 modulo 2^16, and sets `wb_sel` to the pair used.
- R7: `region` is one-hot, with bit 0 for registers, bit 1 for I/O and bit 2 for SRAM. Addresses 0..31 select registers with offset = address. Addresses 32..95 select I/O with offset = address − 32. Addresses 96..1119 select SRAM with offset = address − 96.
- R8: An effective address above 1119 sets `out_of_range`, clears `region` and gives offset 0.
- R9: A request made in one cycle shows up on the outputs after the next rising clock edge. In a cycle with `req_valid` low, the next `out_valid` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer pair select |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Address for direct mode |
| ptr_x | input | 16 | Current X pointer |
| ptr_y | input | 16 | Current Y pointer |
| ptr_z | input | 16 | Current Z pointer |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 16 | Effective address |
| region | output | 3 | One-hot region select |
| local_off | output | 10 | Offset within selected region |
| out_of_range | output | 1 | Address beyond decoded space |
| wb_en | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer pair to write back |
| wb_val | output | 16 | Updated pointer value |

## Verification
The datapath holds no state between requests, so a wrong result can only come from the combinational path or its output registers. Any such fault appears on the ports one cycle after the request that triggered it. Wrong boundary constants show up as a region or offset that is wrong at exactly 31/32, 95/96 or 1119/1120. A wrong pointer select shows up as an address off by the fixed spacing the bench puts between X, Y and Z. Wrap faults appear at pointer values 0 and 0xFFFF.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_IND     = 3'd1,
    AM_DISP    = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_POSTINC = 3'd4
  } amode_e;

  localparam int RG_REG  = 0;
  localparam int RG_IO   = 1;
  localparam int RG_SRAM = 2;
  localparam int RG_W    = 3;

  localparam logic [1:0] PS_X = 2'd0;
  localparam logic [1:0] PS_Y = 2'd1;
  localparam logic [1:0] PS_Z = 2'd2;
endpackage

// File: rtl/dag_ptr_mux.sv
module dag_ptr_mux #(
  parameter int AW = 16
) (
  input  logic [1:0]    sel,
  input  logic [AW-1:0] x,
  input  logic [AW-1:0] y,
  input  logic [AW-1:0] z,
  output logic [AW-1:0] ptr,
  output logic [1:0]    sel_norm
);
  import dag_pkg::*;

  always_comb begin
    unique case (sel)
      PS_X: begin
        ptr      = x;
        sel_norm = PS_X;
      end
      PS_Y: begin
        ptr      = y;
        sel_norm = PS_Y;
      end
      default: begin
        ptr      = z;
        sel_norm = PS_Z;
      end
    endcase
  end
endmodule

// File: rtl/dag_ea_calc.sv
module dag_ea_calc #(
  parameter int AW     = 16,
  parameter int DISP_W = 6
) (
  input  logic [2:0]        mode,
  input  logic [AW-1:0]     ptr,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     direct_addr,
  output logic [AW-1:0]     ea,
  output logic              wb_en,
  output logic [AW-1:0]     wb_val
);
  import dag_pkg::*;

  localparam int PAD_W = AW - DISP_W;

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] ptr_dec;
  logic [AW-1:0] ptr_inc;
  logic [AW-1:0] ptr_off;

  assign disp_ext = {{PAD_W{1'b0}}, disp};
  assign ptr_dec  = ptr - {{(AW-1){1'b0}}, 1'b1};
  assign ptr_inc  = ptr + {{(AW-1){1'b0}}, 1'b1};
  assign ptr_off  = ptr + disp_ext;

  always_comb begin
    ea     = ptr;
    wb_en  = 1'b0;
    wb_val = ptr;
    case (amode_e'(mode))
      AM_DIRECT: ea = direct_addr;
      AM_DISP:   ea = ptr_off;
      AM_PREDEC: begin
        ea     = ptr_dec;
        wb_en  = 1'b1;
        wb_val = ptr_dec;
      end
      AM_POSTINC: begin
        ea     = ptr;
        wb_en  = 1'b1;
        wb_val = ptr_inc;
      end
      default: ea = ptr;
    endcase
  end
endmodule

// File: rtl/dag_region_dec.sv
module dag_region_dec #(
  parameter int AW    = 16,
  parameter int NREG  = 32,
  parameter int NIO   = 64,
  parameter int NSRAM = 1024,
  parameter int OFF_W = 10
) (
  input  logic [AW-1:0]           ea,
  output logic [dag_pkg::RG_W-1:0] region,
  output logic [OFF_W-1:0]        off,
  output logic                    oor
);
  import dag_pkg::*;

  localparam int IO_BASE   = NREG;
  localparam int SRAM_BASE = NREG + NIO;
  localparam int SPACE_END = SRAM_BASE + NSRAM;

  localparam logic [AW-1:0] IO_BASE_A   = AW'(IO_BASE);
  localparam logic [AW-1:0] SRAM_BASE_A = AW'(SRAM_BASE);
  localparam logic [AW-1:0] END_A       = AW'(SPACE_END);

  logic [AW-1:0] io_rel;
  logic [AW-1:0] sram_rel;

  assign io_rel   = ea - IO_BASE_A;
  assign sram_rel = ea - SRAM_BASE_A;

  always_comb begin
    region = '0;
    off    = '0;
    oor    = 1'b0;
    if (ea < IO_BASE_A) begin
      region[RG_REG] = 1'b1;
      off            = ea[OFF_W-1:0];
    end else if (ea < SRAM_BASE_A) begin
      region[RG_IO] = 1'b1;
      off           = io_rel[OFF_W-1:0];
    end else if (ea < END_A) begin
      region[RG_SRAM] = 1'b1;
      off             = sram_rel[OFF_W-1:0];
    end else begin
      oor = 1'b1;
    end
  end
endmodule

// File: rtl/dag_top.sv
module dag_top #(
  parameter int AW     = 16,
  parameter int DISP_W = 6,
  parameter int NREG   = 32,
  parameter int NIO    = 64,
  parameter int NSRAM  = 1024,
  parameter int OFF_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        mode,
  input  logic [1:0]        ptr_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     direct_addr,
  input  logic [AW-1:0]     ptr_x,
  input  logic [AW-1:0]     ptr_y,
  input  logic [AW-1:0]     ptr_z,
  output logic              out_valid,
  output logic [AW-1:0]     eff_addr,
  output logic [2:0]        region,
  output logic [OFF_W-1:0]  local_off,
  output logic              out_of_range,
  output logic              wb_en,
  output logic [1:0]        wb_sel,
  output logic [AW-1:0]     wb_val
);
  logic [AW-1:0]    ptr_c;
  logic [1:0]       sel_c;
  logic [AW-1:0]    ea_c;
  logic             wb_en_c;
  logic [AW-1:0]    wb_val_c;
  logic [2:0]       region_c;
  logic [OFF_W-1:0] off_c;
  logic             oor_c;

  dag_ptr_mux #(.AW(AW)) u_mux (
    .sel      (ptr_sel),
    .x        (ptr_x),
    .y        (ptr_y),
    .z        (ptr_z),
    .ptr      (ptr_c),
    .sel_norm (sel_c)
  );

  dag_ea_calc #(.AW(AW), .DISP_W(DISP_W)) u_calc (
    .mode        (mode),
    .ptr         (ptr_c),
    .disp        (disp),
    .direct_addr (direct_addr),
    .ea          (ea_c),
    .wb_en       (wb_en_c),
    .wb_val      (wb_val_c)
  );

  dag_region_dec #(
    .AW(AW), .NREG(NREG), .NIO(NIO), .NSRAM(NSRAM), .OFF_W(OFF_W)
  ) u_dec (
    .ea     (ea_c),
    .region (region_c),
    .off    (off_c),
    .oor    (oor_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      eff_addr     <= '0;
      region       <= '0;
      local_off    <= '0;
      out_of_range <= 1'b0;
      wb_en        <= 1'b0;
      wb_sel       <= '0;
      wb_val       <= '0;
    end else begin
      out_valid <= req_valid;
      wb_en     <= req_valid & wb_en_c;
      if (req_valid) begin
        eff_addr     <= ea_c;
        region       <= region_c;
        local_off    <= off_c;
        out_of_range <= oor_c;
        wb_sel       <= sel_c;
        wb_val       <= wb_val_c;
      end
    end
  end
endmodule

// File: rtl/dag_top_chk.sv
module dag_top_chk #(
  parameter int AW     = 16,
  parameter int NREG   = 32,
  parameter int NIO    = 64,
  parameter int NSRAM  = 1024,
  parameter int OFF_W  = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             out_valid,
  input logic [AW-1:0]    eff_addr,
  input logic [2:0]       region,
  input logic [OFF_W-1:0] local_off,
  input logic             out_of_range,
  input logic             wb_en,
  input logic [AW-1:0]    wb_val
);
  localparam logic [AW-1:0] IO_A   = AW'(NREG);
  localparam logic [AW-1:0] SRAM_A = AW'(NREG + NIO);
  localparam logic [AW-1:0] END_A  = AW'(NREG + NIO + NSRAM);

  p_onehot_region_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region));

  p_reg_bounds_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && region[0]) |-> (eff_addr < IO_A));

  p_sram_bounds_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && region[2]) |-> (eff_addr >= SRAM_A && eff_addr < END_A));

  p_oor_no_region_r8: assert property (@(posedge clk) disable iff (rst)
    out_of_range |-> (region == 3'b000 && local_off == '0 && eff_addr >= END_A));

  p_wb_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> out_valid);

  p_idle_no_out_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !wb_en));

  p_wb_step_r5: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_val == eff_addr || wb_val == eff_addr + AW'(1)));
endmodule

bind dag_top dag_top_chk #(
  .AW(AW), .NREG(NREG), .NIO(NIO), .NSRAM(NSRAM), .OFF_W(OFF_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .out_valid    (out_valid),
  .eff_addr     (eff_addr),
  .region       (region),
  .local_off    (local_off),
  .out_of_range (out_of_range),
  .wb_en        (wb_en),
  .wb_val       (wb_val)
);

// File: tb/dag_top_bench.sv
module dag_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptr_sel = '0;
  logic [5:0]  disp = '0;
  logic [15:0] direct_addr = '0;
  logic [15:0] ptr_x = '0;
  logic [15:0] ptr_y = '0;
  logic [15:0] ptr_z = '0;
  logic        out_valid;
  logic [15:0] eff_addr;
  logic [2:0]  region;
  logic [9:0]  local_off;
  logic        out_of_range;
  logic        wb_en;
  logic [1:0]  wb_sel;
  logic [15:0] wb_val;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dag_top u_dag_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
    .ptr_sel(ptr_sel), .disp(disp), .direct_addr(direct_addr),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .out_valid(out_valid), .eff_addr(eff_addr), .region(region),
    .local_off(local_off), .out_of_range(out_of_range),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
  );

  task automatic note(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [2:0] m, input logic [1:0] s,
                     input logic [5:0] d, input logic [15:0] da,
                     input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    int p, ea, we, wv, ws, rg, off, oor, f0;
    p  = (s == 2'd0) ? int'(x) : (s == 2'd1) ? int'(y) : int'(z);
    ws = (s == 2'd0) ? 0 : (s == 2'd1) ? 1 : 2;
    we = 0;
    wv = -1;
    case (m)
      3'd0: ea = int'(da);
      3'd2: ea = (p + int'(d)) % 65536;
      3'd3: begin ea = (p + 65535) % 65536; we = 1; wv = ea; end
      3'd4: begin ea = p; we = 1; wv = (p + 1) % 65536; end
      default: ea = p;
    endcase
    oor = 0; off = 0;
    if (ea < 32) begin rg = 1; off = ea; end
    else if (ea < 96) begin rg = 2; off = ea - 32; end
    else if (ea < 1120) begin rg = 4; off = ea - 96; end
    else begin rg = 0; oor = 1; end
    @(negedge clk);
    req_valid = 1'b1; mode = m; ptr_sel = s; disp = d; direct_addr = da;
    ptr_x = x; ptr_y = y; ptr_z = z;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n_checks++;
    f0 = n_fail;
    note(tag, "out_valid", int'(out_valid), 1);
    note(tag, "eff_addr", int'(eff_addr), ea);
    note("R7", "region", int'(region), rg);
    note("R7", "local_off", int'(local_off), off);
    note("R8", "out_of_range", int'(out_of_range), oor);
    note(tag, "wb_en", int'(wb_en), we);
    if (we == 1) begin
      note(tag, "wb_val", int'(wb_val), wv);
      note(tag, "wb_sel", int'(wb_sel), ws);
    end
    if (n_fail > f0) n_fail = f0 + 1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
    end
  end

  initial begin
    logic [15:0] pv [10];
    int f0;
    pv = '{16'd0, 16'd1, 16'd31, 16'd32, 16'd95, 16'd96,
           16'd1119, 16'd1120, 16'hFFFF, 16'h8000};

    // R1: reset state, during reset and in first cycle after
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    f0 = n_fail;
    note("R1", "out_valid", int'(out_valid), 0);
    note("R1", "wb_en", int'(wb_en), 0);
    note("R1", "region", int'(region), 0);
    note("R1", "eff_addr", int'(eff_addr), 0);
    if (n_fail > f0) n_fail = f0 + 1;
    rst = 1'b0;
    @(negedge clk);
    n_checks++;
    f0 = n_fail;
    note("R1", "out_valid", int'(out_valid), 0);
    note("R1", "out_of_range", int'(out_of_range), 0);
    if (n_fail > f0) n_fail = f0 + 1;

    // R2/R7/R8: direct sweep over the decoded space and beyond
    for (int a = 0; a < 1136; a++)
      run("R2", 3'd0, 2'd0, 6'd0, 16'(a), 16'd5, 16'd6, 16'd7);
    run("R2", 3'd0, 2'd1, 6'd0, 16'hFFFF, 16'd5, 16'd6, 16'd7);
    run("R2", 3'd0, 2'd2, 6'd0, 16'h8000, 16'd5, 16'd6, 16'd7);

    // R3..R6: modes x selects x boundary pointers x displacements
    for (int m = 1; m < 8; m++)
      for (int s = 0; s < 4; s++)
        for (int i = 0; i < 10; i++)
          for (int k = 0; k < 3; k++) begin
            logic [5:0] dd;
            string t;
            dd = (k == 0) ? 6'd0 : (k == 1) ? 6'd1 : 6'd63;
            t = (m == 2) ? "R4" : (m == 3) ? "R5" : (m == 4) ? "R6" : "R3";
            run(t, 3'(m), 2'(s), dd, 16'h1234, pv[i], pv[i] + 16'd3, pv[i] + 16'd7);
          end

    // R4: displacement ramp over Z across region boundaries
    for (int i = 0; i < 1130; i++)
      run("R4", 3'd2, 2'd2, 6'(i % 64), 16'd0, 16'd9, 16'd9, 16'(i));

    // R6: post-increment wrap, R5: pre-decrement wrap
    run("R6", 3'd4, 2'd1, 6'd0, 16'd0, 16'd0, 16'hFFFF, 16'd0);
    run("R5", 3'd3, 2'd0, 6'd0, 16'd0, 16'd0, 16'd0, 16'd0);

    // R9: idle cycle gives no valid and no write-back
    run("R6", 3'd4, 2'd0, 6'd0, 16'd0, 16'd50, 16'd0, 16'd0);
    @(negedge clk);
    req_valid = 1'b0; mode = 3'd4;
    @(posedge clk);
    @(negedge clk);
    n_checks++;
    f0 = n_fail;
    note("R9", "out_valid", int'(out_valid), 0);
    note("R9", "wb_en", int'(wb_en), 0);
    if (n_fail > f0) n_fail = f0 + 1;

    done = 1'b1;
    summary();
  end
endmodule